// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Address Sequencer

A synchronous single-port memory whose reads are flow-through. A clock edge registers an address, and the word stored there appears on the read port in the same cycle. No further pipeline register sits on the read path. A built-in two-bit counter generates the rest of a four-beat burst. Bursts run either in interleaved order, where the low bits are the captured address XOR the beat count, or in linear order, where the low bits are the captured address plus the beat count, modulo four. A level on the mode input selects between the two orders.

A burst starts on the processor strobe or the controller strobe. Three chip enables qualify the access. Writes are controlled by a global write, a byte-write enable and one select per byte lane. The output enable and the sleep input act without waiting for a clock. The data bus is split into separate read data, write data and read-drive-enable ports, and a pad ring builds the bidirectional pins from them.

Top module: `fts_burst_sram`

## Requirements
- R1: A low level on either `ads_proc_n` or `ads_ctrl_n` at a rising edge, with sleep low, captures `addr`. The chip is selected when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. If the chip is selected and `oe_n` is low, then after that same edge `rdata_oe` is 1 and `rdata` carries the word stored at the captured address.
- R2: With `burst_mode`=1, beat k (k = 0..3) of a burst addresses low bits equal to captured_low XOR k.
- R3: With `burst_mode`=0, beat k addresses low bits equal to (captured_low + k) mod 4. In both orders the address bits above bit 1 keep their captured value for the whole burst.
- R4: After a burst starts, the beat count moves on only at an edge where `adv_n` is low and no strobe is asserted. With `adv_n` high, the same word stays addressed.
- R5: A strobe that samples the chip as deselected (any enable inactive) ends the burst. After it, `rdata_oe` is 0, and write commands change no memory word until the next selected strobe.
- R6: At an edge inside a burst with no strobe, `gw_n`=0 writes every byte lane of `wdata` to the current burst address, whatever `bwe_n` and `bsel_n` are.
- R7: With `gw_n`=1 and `bwe_n`=0, only the lanes i with `bsel_n[i]`=0 are written. Lane i is `wdata[8*i+7:8*i]`. The other lanes keep their stored value.
- R8: `gw_n`=1 with `bwe_n`=1 is a read: memory is unchanged, even with every `bsel_n` bit low. So is `gw_n`=1 with `bwe_n`=0 and all `bsel_n` bits high.
- R9: `oe_n`=1 forces `rdata_oe` to 0 without waiting for a clock. The burst state is kept, so the output comes back as soon as `oe_n` is low again.
- R10: While `sleep`=1, `rdata_oe` is 0, no write happens and any burst in progress ends. Stored contents are kept.
- R11: While `rst_n` is low, and after reset until the first selected strobe, `rdata_oe` is 0.
- R12: At an edge where a strobe is asserted, the write controls are ignored. The edge only starts a new burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of burst state |
| addr | input | ADDR_W | Address captured by a strobe |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | BYTES | Per-lane byte select, active low |
| wdata | input | BYTES*BYTE_W | Write data |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| sleep | input | 1 | Sleep, asynchronous, active high |
| burst_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| rdata | output | BYTES*BYTE_W | Flow-through read data |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
The assertions assume that `burst_mode` changes only between bursts. The address-hold check allows a changing mode, but the ordering checks rely on a steady mode. The assertions also assume that the strobes, enables and write controls are free of X after reset. The stimulus sets the mode only in the cycle that issues a strobe and holds every control at a defined idle level. Reads in the bench are made only at addresses the bench has written beforehand, so no comparison sees uninitialised storage.

// File: rtl/fts_pkg.sv
package fts_pkg;

   // Low two address bits for a given beat of a burst.
   function automatic logic [1:0] beat_low(input logic [1:0] start_low,
                                           input logic [1:0] beat,
                                           input logic       interleave);
      return interleave ? (start_low ^ beat) : (start_low + beat);
   endfunction

endpackage

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              sel_in,
   input  logic              clear,
   input  logic              step,
   input  logic              interleave,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              active
);
   import fts_pkg::*;

   localparam int HI_W = ADDR_W - 2;

   logic [ADDR_W-1:0] base_q;
   logic [1:0]        beat_q;

   if (ADDR_W < 3) begin : g_bad_width
      $error("fts_burst_ctr: ADDR_W must be at least 3");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         base_q <= '0;
         beat_q <= '0;
      end else if (clear) begin
         active <= 1'b0;
      end else if (load) begin
         active <= sel_in;
         base_q <= addr_in;
         beat_q <= '0;
      end else if (active && step) begin
         beat_q <= beat_q + 2'd1;
      end
   end

   always_comb begin
      cur_addr[ADDR_W-1:2] = base_q[ADDR_W-1:2];
      cur_addr[1:0]        = beat_low(base_q[1:0], beat_q, interleave);
   end

   logic [HI_W-1:0] unused_hi;
   assign unused_hi = cur_addr[ADDR_W-1:2];

endmodule

// File: rtl/fts_wr_decode.sv
module fts_wr_decode #(
   parameter int BYTES = 4
) (
   input  logic             cycle_ok,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [BYTES-1:0] bsel_n,
   output logic [BYTES-1:0] lane_we
);
   if (BYTES < 1) begin : g_bad_bytes
      $error("fts_wr_decode: BYTES must be at least 1");
   end

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign lane_we[i] = cycle_ok & (~gw_n | (~bwe_n & ~bsel_n[i]));
   end

endmodule

// File: rtl/fts_byte_mem.sv
module fts_byte_mem #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic [BYTES-1:0]        lane_we,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [BYTES*BYTE_W-1:0] wdata,
   output logic [BYTES*BYTE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DEPTH * BYTES > 4096) begin : g_too_big
      $error("fts_byte_mem: storage exceeds elaboration limit");
   end

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      logic [BYTE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[i]) store[addr] <= wdata[i*BYTE_W +: BYTE_W];
      end

      assign rdata[i*BYTE_W +: BYTE_W] = store[addr];
   end

endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    ads_proc_n,
   input  logic                    ads_ctrl_n,
   input  logic                    adv_n,
   input  logic                    ce1_n,
   input  logic                    ce2,
   input  logic                    ce3_n,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [BYTES-1:0]        bsel_n,
   input  logic [BYTES*BYTE_W-1:0] wdata,
   input  logic                    oe_n,
   input  logic                    sleep,
   input  logic                    burst_mode,
   output logic [BYTES*BYTE_W-1:0] rdata,
   output logic                    rdata_oe
);
   logic              strobe;
   logic              chip_sel;
   logic              burst_on;
   logic              wr_ok;
   logic [ADDR_W-1:0] cur_addr;
   logic [BYTES-1:0]  lane_we;

   assign strobe   = ~ads_proc_n | ~ads_ctrl_n;
   assign chip_sel = ~ce1_n & ce2 & ~ce3_n;
   assign wr_ok    = burst_on & ~strobe & ~sleep;

   fts_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (strobe),
      .sel_in     (chip_sel),
      .clear      (sleep),
      .step       (~adv_n),
      .interleave (burst_mode),
      .addr_in    (addr),
      .cur_addr   (cur_addr),
      .active     (burst_on)
   );

   fts_wr_decode #(.BYTES(BYTES)) u_wdec (
      .cycle_ok (wr_ok),
      .gw_n     (gw_n),
      .bwe_n    (bwe_n),
      .bsel_n   (bsel_n),
      .lane_we  (lane_we)
   );

   fts_byte_mem #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_mem (
      .clk     (clk),
      .lane_we (lane_we),
      .addr    (cur_addr),
      .wdata   (wdata),
      .rdata   (rdata)
   );

   assign rdata_oe = burst_on & ~oe_n & ~sleep;

endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              ads_proc_n,
   input logic              ads_ctrl_n,
   input logic              adv_n,
   input logic              ce1_n,
   input logic              ce2,
   input logic              ce3_n,
   input logic              oe_n,
   input logic              sleep,
   input logic              burst_mode,
   input logic              rdata_oe,
   input logic [ADDR_W-1:0] cur_addr
);
   logic stb;
   logic sel;
   assign stb = ~ads_proc_n | ~ads_ctrl_n;
   assign sel = ~ce1_n & ce2 & ~ce3_n;

   assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !rdata_oe);

   assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rdata_oe);

   assert_deselect_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !sel && !sleep) |=> !rdata_oe);

   assert_capture_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !sleep) |=> (cur_addr == $past(addr)));

   assert_hold_no_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb && adv_n) |=> ($stable(cur_addr) || !$stable(burst_mode)));

   assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

endmodule

bind fts_burst_sram fts_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr       (addr),
   .ads_proc_n (ads_proc_n),
   .ads_ctrl_n (ads_ctrl_n),
   .adv_n      (adv_n),
   .ce1_n      (ce1_n),
   .ce2        (ce2),
   .ce3_n      (ce3_n),
   .oe_n       (oe_n),
   .sleep      (sleep),
   .burst_mode (burst_mode),
   .rdata_oe   (rdata_oe),
   .cur_addr   (cur_addr)
);

// File: tb/fts_burst_sram_tb.sv
module fts_burst_sram_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int NB = 4;
   localparam int BW = 8;
   localparam int DW = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
   logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
   logic          gw_n = 1'b1, bwe_n = 1'b1;
   logic [NB-1:0] bsel_n = '1;
   logic [DW-1:0] wdata = '0;
   logic          oe_n = 1'b0, sleep = 1'b0, burst_mode = 1'b0;
   logic [DW-1:0] rdata;
   logic          rdata_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   fts_burst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ads_proc_n(ads_proc_n),
      .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
      .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
      .wdata(wdata), .oe_n(oe_n), .sleep(sleep), .burst_mode(burst_mode),
      .rdata(rdata), .rdata_oe(rdata_oe)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model
   logic [DW-1:0] ref_mem [1<<AW];
   logic          m_act = 1'b0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_beat = '0;

   typedef struct {
      logic          oe;
      logic [DW-1:0] data;
      string         req;
   } exp_t;
   exp_t q[$];

   function automatic logic [AW-1:0] m_cur();
      logic [1:0] lo;
      lo = burst_mode ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
      return {m_base[AW-1:2], lo};
   endfunction

   // driver: called right after a falling edge with inputs already set
   task automatic cyc(input string req);
      exp_t e;
      logic stb, sel;
      logic [AW-1:0] c;
      stb = !ads_proc_n || !ads_ctrl_n;
      sel = !ce1_n && ce2 && !ce3_n;
      if (sleep) m_act = 1'b0;
      else if (stb) begin
         m_act = sel; m_base = addr; m_beat = 2'd0;
      end else if (m_act) begin
         c = m_cur();
         for (int i = 0; i < NB; i++)
            if (!gw_n || (!bwe_n && !bsel_n[i]))
               ref_mem[c][i*BW +: BW] = wdata[i*BW +: BW];
         if (!adv_n) m_beat = m_beat + 2'd1;
      end
      e.oe   = m_act && !oe_n && !sleep;
      e.data = ref_mem[m_cur()];
      e.req  = req;
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic idle();
      ads_proc_n = 1; ads_ctrl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1;
      bsel_n = '1; ce1_n = 0; ce2 = 1; ce3_n = 0;
   endtask

   task automatic start(input logic [AW-1:0] a, input bit use_proc,
                        input logic md, input string req);
      idle();
      addr = a; burst_mode = md;
      if (use_proc) ads_proc_n = 0; else ads_ctrl_n = 0;
      cyc(req);
      idle();
   endtask

   task automatic beat(input logic g, input logic b, input logic [NB-1:0] s,
                       input logic [DW-1:0] d, input logic adv, input string req);
      idle();
      gw_n = g; bwe_n = b; bsel_n = s; wdata = d; adv_n = adv;
      cyc(req);
      idle();
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rdata_oe !== e.oe) begin
               errors++;
               $display("FAIL %s: rdata_oe=%b expected %b", e.req, rdata_oe, e.oe);
            end else if (e.oe && rdata !== e.data) begin
               errors++;
               $display("FAIL %s: rdata=%h expected %h", e.req, rdata, e.data);
            end
         end
      end
   end

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (rdata_oe !== 1'b0) begin
         errors++;
         $display("FAIL R11: rdata_oe=%b expected 0 in reset", rdata_oe);
      end
      rst_n = 1;
      @(negedge clk);
      checks++;
      if (rdata_oe !== 1'b0) begin
         errors++;
         $display("FAIL R11: rdata_oe=%b expected 0 after reset", rdata_oe);
      end

      // fill 8..11 with global writes, linear order (R6, R3)
      start(8'h08, 0, 0, "R1 ctrl strobe");
      for (int k = 0; k < 4; k++)
         beat(0, 1, '1, 32'hA0B0C000 + 32'(k), 0, "R6 global write");
      // fill 0x24..0x27 too
      start(8'h24, 1, 0, "R1 proc strobe");
      for (int k = 0; k < 4; k++)
         beat(0, 0, 4'b1010, 32'h5500EE00 + 32'(k), 0, "R6 gw overrides bytes");

      // interleaved read from 9: 9,8,11,10 (R2)
      start(8'h09, 1, 1, "R1 read start");
      for (int k = 0; k < 4; k++) beat(1, 1, '1, '0, 0, "R2 interleaved");
      // linear read from 0x26: 26,27,24,25 (R3)
      start(8'h26, 0, 0, "R1 read start");
      for (int k = 0; k < 4; k++) beat(1, 1, '1, '0, 0, "R3 linear wrap");
      // interleaved from 0x0B: B,A,9,8 (R2)
      start(8'h0B, 0, 1, "R1 read start");
      for (int k = 0; k < 4; k++) beat(1, 1, '1, '0, 0, "R2 interleaved top");

      // hold without advance (R4)
      start(8'h0A, 1, 0, "R1 read start");
      beat(1, 1, '1, '0, 1, "R4 hold");
      beat(1, 1, '1, '0, 1, "R4 hold");
      beat(1, 1, '1, '0, 0, "R4 advance");

      // byte write lanes 0 and 2 at 0x09 (R7)
      start(8'h09, 0, 0, "R1 start");
      beat(1, 0, 4'b1010, 32'h11223344, 1, "R7 byte write");
      beat(1, 1, '1, '0, 1, "R7 merged read");
      beat(1, 0, 4'b0111, 32'hFF000000, 1, "R7 lane3 write");
      // reads that must not write (R8)
      beat(1, 1, 4'b0000, 32'hDEADBEEF, 1, "R8 bwe high");
      beat(1, 0, 4'b1111, 32'hDEADBEEF, 1, "R8 no lane");
      beat(1, 1, '1, '0, 1, "R8 unchanged");

      // strobe priority over write (R12)
      idle(); addr = 8'h08; burst_mode = 0; ads_ctrl_n = 0; gw_n = 0;
      wdata = 32'hBADBAD00; cyc("R12 strobe ignores write"); idle();
      beat(1, 1, '1, '0, 1, "R12 data kept");

      // deselect variants (R5)
      idle(); addr = 8'h08; ads_ctrl_n = 0; ce2 = 0; cyc("R5 ce2 low"); idle();
      beat(0, 1, '1, 32'h0BAD0BAD, 0, "R5 write ignored");
      idle(); addr = 8'h08; ads_proc_n = 0; ce1_n = 1; cyc("R5 ce1 high"); idle();
      idle(); addr = 8'h08; ads_proc_n = 0; ce3_n = 1; cyc("R5 ce3 high"); idle();
      start(8'h08, 0, 0, "R5 reselect");
      beat(1, 1, '1, '0, 0, "R5 contents kept");
      // deselect mid-burst
      idle(); addr = 8'h0A; ads_ctrl_n = 0; ce3_n = 1; cyc("R5 end burst"); idle();
      beat(1, 1, '1, '0, 0, "R5 stays off");

      // output enable (R9)
      start(8'h24, 0, 0, "R1 start");
      oe_n = 1; beat(1, 1, '1, '0, 1, "R9 oe high");
      oe_n = 0; beat(1, 1, '1, '0, 0, "R9 oe low again");

      // sleep (R10)
      sleep = 1; beat(0, 1, '1, 32'hCAFECAFE, 0, "R10 sleep write blocked");
      sleep = 1; beat(1, 1, '1, '0, 1, "R10 sleep off");
      sleep = 0; beat(1, 1, '1, '0, 1, "R10 burst ended");
      start(8'h25, 1, 0, "R10 wake start");
      beat(1, 1, '1, '0, 1, "R10 contents kept");

      repeat (3) @(posedge clk);
      finish_up();
   end

endmodule